// File: doc/BRIEF.md
# Parallel 8-point Fermat number transform engine

This block computes an 8-point number-theoretic transform over the ring of integers modulo 17 (2^4+1), using 2 as the eighth root of unity. All eight samples enter in one cycle together with a start strobe. A fully parallel radix-2 decimation-in-time network then processes them, and eight results appear four cycles later together with a one-cycle done pulse. A new transform may start on every cycle. Each transform carries its own direction bit, so forward and inverse transforms can be interleaved freely.

The samples go through four register stages. The first stage turns plain binary samples into pairs of 4-bit words whose sum, plus a fixed offset, equals the residue. This stage also performs the first butterfly layer. The next two stages are butterfly layers with no carry chain. In these layers a twiddle power of two is a rotate-and-invert of each word, and the additions use modulo-17 4-2 compressors. The last stage does the only carry-propagate addition. It produces a diminished-1 code (true value minus one) and a zero flag, because a true value of 0 has no 4-bit diminished-1 code. In inverse mode the last stage reads the forward result at the mirrored position, and it scales by 1/8 (a rotation by five places).

Top module: `fermat_xform`

## Requirements
- R1: With `inverse`=0, output k has the true value Y_k = sum over i of x_i·2^(i·k) mod 17. Here x_i is the sample on lane bitrev3(i) of `samples`, so lane p carries x with the index bits of p reversed (lane 1 holds x_4, lane 3 holds x_6). Outputs are in natural order.
- R2: Each sample is a 5-bit unsigned number and is taken modulo 17, so the codes 17 to 31 act as the values 0 to 14.
- R3: An output with true value v in 1..16 shows `dim_out`=v−1 and `zero_out`=0. A true value of 0 shows `zero_out`=1 and `dim_out`=0.
- R4: With `inverse`=1, output p has the true value 15·(sum over k of X_k·2^(−p·k)) mod 17, where 15 is the inverse of 8 modulo 17. X_k is taken from the lanes in the same bit-reversed placement as R1.
- R5: Feed the true values of a forward result, in bit-reversed placement, to an inverse transform. The inverse then returns the original samples reduced modulo 17.
- R6: `done` is high in the fourth cycle after a cycle in which `start` was sampled high, and is high for one cycle for each start.
- R7: `start` may be high on consecutive cycles. Each transform uses the `inverse` value sampled with its own start, and the results come out in start order, one per cycle.
- R8: `dim_out` and `zero_out` change only in a cycle where `done` is high. `samples` and `inverse` are ignored while `start` is low.
- R9: While `rst_n` is low, `done` is 0 and every lane shows `dim_out`=0 and `zero_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture `samples` and `inverse` this cycle |
| inverse | input | 1 | 0 forward transform, 1 inverse transform |
| samples | input | 8x5 | Eight binary samples, lane p at bits [5p+4:5p], bit-reversed placement |
| done | output | 1 | One-cycle pulse when a result is presented |
| dim_out | output | 8x4 | Diminished-1 result per lane, natural order |
| zero_out | output | 8 | Per-lane flag for a true result of 0 |

## Verification
The checker assumes that `start` is never sampled as unknown once reset is released. It also assumes that every start leads to exactly one result four cycles later, whatever follows on the inputs. The bench drives `start` only from its own tasks, one level per cycle, and keeps `rst_n` low until all inputs hold defined values. The zero-input property holds only for an exactly all-zero sample word. The bench therefore uses both literal zeros and the codes 17 and above, which must reduce to zero-like residues without matching that property.

// File: rtl/fermat_xform_pkg.sv
package fermat_xform_pkg;

  // transform size follows from the Fermat index t: n = 2^t, N = 2n
  localparam int T_EXP         = 2;
  localparam int WORD_W        = 2 ** T_EXP;
  localparam int NPOINT        = 2 * WORD_W;
  localparam int LOG2N         = T_EXP + 1;
  localparam int SAMPLE_W      = WORD_W + 1;
  localparam int MODULUS       = (2 ** WORD_W) + 1;
  // 2 has order N, so 2^(N - log2N) is the inverse of N
  localparam int INV_SCALE_ROT = NPOINT - LOG2N;
  localparam int LATENCY       = LOG2N + 1;

  typedef logic [WORD_W-1:0] word_t;

  // carry-save pair: residue = s + c + 2 (mod 2^n+1)
  typedef struct packed {
    word_t s;
    word_t c;
  } cs_pair_t;

  typedef cs_pair_t [NPOINT-1:0] cs_vec_t;

  // doubling of a diminished-1 word: shift up, invert the bit that leaves
  function automatic word_t rot1(input word_t w);
    return {w[WORD_W-2:0], ~w[WORD_W-1]};
  endfunction

  function automatic cs_pair_t pair_rot1(input cs_pair_t p);
    cs_pair_t r;
    r.s = rot1(p.s);
    r.c = rot1(p.c);
    return r;
  endfunction

  // multiply a pair by 2^k, k below NPOINT
  function automatic cs_pair_t pair_rotk(input cs_pair_t p, input int k);
    cs_pair_t r;
    r = p;
    for (int i = 0; i < NPOINT; i++) begin
      if (i < k) r = pair_rot1(r);
    end
    return r;
  endfunction

  function automatic cs_pair_t pair_neg(input cs_pair_t p);
    cs_pair_t r;
    r.s = ~p.s;
    r.c = ~p.c;
    return r;
  endfunction

  // 3-2 counter modulo 2^n+1: x+y+z = s + c - 1
  function automatic cs_pair_t csa3(input word_t x, input word_t y, input word_t z);
    cs_pair_t r;
    word_t    maj;
    maj = (x & y) | (x & z) | (y & z);
    r.s = x ^ y ^ z;
    r.c = rot1(maj);
    return r;
  endfunction

  // 4-2 compressor modulo 2^n+1: a+b+c+d = s + c - 2
  function automatic cs_pair_t comp4(input word_t a, input word_t b,
                                     input word_t c, input word_t d);
    cs_pair_t t;
    t = csa3(a, b, c);
    return csa3(t.s, t.c, d);
  endfunction

  function automatic cs_pair_t pair_add(input cs_pair_t u, input cs_pair_t v);
    return comp4(u.s, u.c, v.s, v.c);
  endfunction

endpackage

// File: rtl/fermat_conv_stage.sv
module fermat_conv_stage
  import fermat_xform_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               valid_i,
  input  logic                               mode_i,
  input  logic [NPOINT-1:0][SAMPLE_W-1:0]    samples_i,
  output logic                               valid_o,
  output logic                               mode_o,
  output cs_vec_t                            pairs_o
);

  localparam int NBFLY = NPOINT / 2;

  cs_vec_t pairs_nx;

  // binary sample a = 2^n*ah + al is al - ah modulo 2^n+1
  for (genvar b = 0; b < NBFLY; b++) begin : g_conv
    word_t lo_a, lo_b, hi_a, hi_b;

    assign lo_a = samples_i[2*b][WORD_W-1:0];
    assign lo_b = samples_i[2*b+1][WORD_W-1:0];
    assign hi_a = {{(WORD_W-1){1'b0}}, samples_i[2*b][WORD_W]};
    assign hi_b = {{(WORD_W-1){1'b0}}, samples_i[2*b+1][WORD_W]};

    // sum lane: al + bl + (-ah-2) + (-bh-2), the offsets cancel the pair bias
    assign pairs_nx[2*b]   = comp4(lo_a, lo_b, ~hi_a, ~hi_b);
    // difference lane: al + (-bl-2) + (-ah-2) + bh
    assign pairs_nx[2*b+1] = comp4(lo_a, ~lo_b, ~hi_a, hi_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      mode_o  <= 1'b0;
      pairs_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mode_o  <= mode_i;
        pairs_o <= pairs_nx;
      end
    end
  end

endmodule

// File: rtl/fermat_bfly_stage.sv
module fermat_bfly_stage
  import fermat_xform_pkg::*;
#(
  parameter int STAGE = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid_i,
  input  logic    mode_i,
  input  cs_vec_t pairs_i,
  output logic    valid_o,
  output logic    mode_o,
  output cs_vec_t pairs_o
);

  localparam int NBFLY     = NPOINT / 2;
  localparam int HALF_SPAN = 2 ** (STAGE - 1);
  localparam int TW_STEP   = NPOINT / (2 * HALF_SPAN);

  cs_vec_t pairs_nx;

  for (genvar b = 0; b < NBFLY; b++) begin : g_bfly
    localparam int GRP  = b / HALF_SPAN;
    localparam int IDX  = b % HALF_SPAN;
    localparam int TOP  = GRP * 2 * HALF_SPAN + IDX;
    localparam int BOT  = TOP + HALF_SPAN;
    localparam int EXPO = IDX * TW_STEP;

    cs_pair_t tw_lo;

    assign tw_lo          = pair_rotk(pairs_i[BOT], EXPO);
    assign pairs_nx[TOP]  = pair_add(pairs_i[TOP], tw_lo);
    assign pairs_nx[BOT]  = pair_add(pairs_i[TOP], pair_neg(tw_lo));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      mode_o  <= 1'b0;
      pairs_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mode_o  <= mode_i;
        pairs_o <= pairs_nx;
      end
    end
  end

endmodule

// File: rtl/fermat_final_stage.sv
module fermat_final_stage
  import fermat_xform_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           valid_i,
  input  logic                           mode_i,
  input  cs_vec_t                        pairs_i,
  output logic                           done_o,
  output logic [NPOINT-1:0][WORD_W-1:0]  dim_o,
  output logic [NPOINT-1:0]              zero_o
);

  localparam logic [WORD_W:0] ONE_X  = (WORD_W+1)'(1);
  localparam logic [WORD_W:0] MOD_X  = (WORD_W+1)'(MODULUS);
  localparam logic [WORD_W:0] NEG1_X = (WORD_W+1)'(2 ** WORD_W);

  logic [NPOINT-1:0][WORD_W-1:0] dim_nx;
  logic [NPOINT-1:0]             zero_nx;

  for (genvar p = 0; p < NPOINT; p++) begin : g_lane
    localparam int MIRROR = (NPOINT - p) % NPOINT;

    cs_pair_t        picked;
    cs_pair_t        scaled;
    logic [WORD_W:0] raw;
    logic [WORD_W:0] red;

    // inverse: mirrored forward position, then times 1/N
    assign picked = mode_i ? pairs_i[MIRROR] : pairs_i[p];
    assign scaled = mode_i ? pair_rotk(picked, INV_SCALE_ROT) : picked;

    // s + c + 1 is the diminished-1 code before reduction
    assign raw = {1'b0, scaled.s} + {1'b0, scaled.c} + ONE_X;
    assign red = (raw >= MOD_X) ? (raw - MOD_X) : raw;

    assign zero_nx[p] = (red == NEG1_X);
    assign dim_nx[p]  = zero_nx[p] ? '0 : red[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      dim_o  <= '0;
      zero_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        dim_o  <= dim_nx;
        zero_o <= zero_nx;
      end
    end
  end

endmodule

// File: rtl/fermat_xform.sv
module fermat_xform
  import fermat_xform_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             inverse,
  input  logic [NPOINT-1:0][SAMPLE_W-1:0]  samples,
  output logic                             done,
  output logic [NPOINT-1:0][WORD_W-1:0]    dim_out,
  output logic [NPOINT-1:0]                zero_out
);

  cs_vec_t stage_data [LOG2N:1];
  logic    stage_vld  [LOG2N:1];
  logic    stage_mode [LOG2N:1];

  fermat_conv_stage i_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (start),
    .mode_i    (inverse),
    .samples_i (samples),
    .valid_o   (stage_vld[1]),
    .mode_o    (stage_mode[1]),
    .pairs_o   (stage_data[1])
  );

  for (genvar s = 2; s <= LOG2N; s++) begin : g_stage
    fermat_bfly_stage #(
      .STAGE (s)
    ) i_bfly (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (stage_vld[s-1]),
      .mode_i  (stage_mode[s-1]),
      .pairs_i (stage_data[s-1]),
      .valid_o (stage_vld[s]),
      .mode_o  (stage_mode[s]),
      .pairs_o (stage_data[s])
    );
  end

  fermat_final_stage i_final (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (stage_vld[LOG2N]),
    .mode_i  (stage_mode[LOG2N]),
    .pairs_i (stage_data[LOG2N]),
    .done_o  (done),
    .dim_o   (dim_out),
    .zero_o  (zero_out)
  );

endmodule

// File: rtl/fermat_xform_chk.sv
module fermat_xform_chk
  import fermat_xform_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input logic                             start,
  input logic [NPOINT-1:0][SAMPLE_W-1:0]  samples,
  input logic                             done,
  input logic [NPOINT-1:0][WORD_W-1:0]    dim_out,
  input logic [NPOINT-1:0]                zero_out
);

  logic [LATENCY-1:0] start_sh;
  logic [LATENCY-1:0] zin_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_sh <= '0;
      zin_sh   <= '0;
    end else begin
      start_sh <= {start_sh[LATENCY-2:0], start};
      zin_sh   <= {zin_sh[LATENCY-2:0], start && (samples == '0)};
    end
  end

  // R6: result pulse follows each start by the pipeline depth
  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done == start_sh[LATENCY-1]);

  // R8: outputs move only together with done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dim_out) && $stable(zero_out)));

  // R1: transform of an all-zero block is zero on every lane
  a_r1_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    zin_sh[LATENCY-1] |-> (&zero_out));

  for (genvar l = 0; l < NPOINT; l++) begin : g_lane_chk
    // R3: a flagged zero carries an all-zero code word
    a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      zero_out[l] |-> (dim_out[l] == '0));
  end

endmodule

bind fermat_xform fermat_xform_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .samples  (samples),
  .done     (done),
  .dim_out  (dim_out),
  .zero_out (zero_out)
);

// File: tb/test_fermat_xform.sv
module test_fermat_xform;

  localparam int NP  = 8;
  localparam int MD  = 17;
  localparam int LAT = 4;

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic                 inverse;
  logic [NP-1:0][4:0]   samples;
  logic                 done;
  logic [NP-1:0][3:0]   dim_out;
  logic [NP-1:0]        zero_out;

  fermat_xform i_fermat_xform (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .inverse  (inverse),
    .samples  (samples),
    .done     (done),
    .dim_out  (dim_out),
    .zero_out (zero_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  int    q_due[$];
  int    q_val[$];
  string q_tag[$];
  int    hold_dim[NP];
  int    hold_zero[NP];
  string idle_tag = "R9";
  int    xs[NP];
  int    ln[NP];
  int    big[NP];

  function automatic int md(input int v);
    return ((v % MD) + MD) % MD;
  endfunction

  function automatic int pw2(input int e);
    int r;
    r = 1;
    for (int i = 0; i < (e % NP); i++) r = (r * 2) % MD;
    return r;
  endfunction

  function automatic int brev(input int p);
    return ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
  endfunction

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit    exp_done;
    int    v;
    int    mism;
    string tag;
    @(negedge clk);
    cyc++;
    exp_done = (q_due.size() > 0) && (q_due[0] == cyc);
    check_int("R6", "done", int'(done), int'(exp_done));
    if (exp_done) begin
      void'(q_due.pop_front());
      tag = q_tag.pop_front();
      for (int l = 0; l < NP; l++) begin
        v = q_val.pop_front();
        hold_zero[l] = (v == 0) ? 1 : 0;
        hold_dim[l]  = (v == 0) ? 0 : v - 1;
        check_int(tag, $sformatf("lane %0d dim", l), int'(dim_out[l]), hold_dim[l]);
        check_int(tag, $sformatf("lane %0d zero", l), int'(zero_out[l]), hold_zero[l]);
      end
    end else begin
      mism = 0;
      for (int l = 0; l < NP; l++) begin
        if (int'(dim_out[l]) != hold_dim[l] || int'(zero_out[l]) != hold_zero[l]) mism++;
      end
      check_int(idle_tag, "held lanes mismatching", mism, 0);
    end
  endtask

  task automatic launch(input bit mode, input int lane[NP], input string tag);
    int x[NP];
    int acc;
    for (int i = 0; i < NP; i++) x[i] = md(lane[brev(i)]);
    for (int k = 0; k < NP; k++) begin
      acc = 0;
      for (int i = 0; i < NP; i++) begin
        if (!mode) acc += x[i] * pw2(i * k);
        else       acc += x[i] * pw2(NP - ((i * k) % NP));
      end
      q_val.push_back(mode ? md(acc * 15) : md(acc));
    end
    for (int p = 0; p < NP; p++) samples[p] = lane[p][4:0];
    inverse = mode;
    start   = 1'b1;
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
    tick();
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int p = 0; p < NP; p++) samples[p] = 5'($urandom_range(31, 0));
      inverse = 1'($urandom_range(1, 0));
      tick();
    end
  endtask

  task automatic drain();
    start = 1'b0;
    while (q_due.size() > 0) idle(1);
    idle(1);
  endtask

  task automatic round_trip(input int x[NP]);
    int lane[NP];
    int spec[NP];
    for (int p = 0; p < NP; p++) lane[p] = x[brev(p)];
    launch(1'b0, lane, "R5 forward leg");
    drain();
    for (int m = 0; m < NP; m++) spec[m] = zero_out[m] ? 0 : int'(dim_out[m]) + 1;
    for (int p = 0; p < NP; p++) lane[p] = spec[brev(p)];
    launch(1'b1, lane, "R5 inverse leg");
    drain();
    for (int m = 0; m < NP; m++)
      check_int("R5", $sformatf("round trip sample %0d", m),
                zero_out[m] ? 0 : int'(dim_out[m]) + 1, md(x[m]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    inverse = 1'b0;
    samples = '0;
    for (int l = 0; l < NP; l++) begin
      hold_dim[l]  = 0;
      hold_zero[l] = 0;
    end
    // R9: reset state
    repeat (3) tick();
    rst_n    = 1'b1;
    idle_tag = "R8";
    idle(2);

    // R1: all zero, impulse, ramp
    for (int p = 0; p < NP; p++) ln[p] = 0;
    launch(1'b0, ln, "R1 zeros");
    idle(4);
    ln[0] = 1;
    launch(1'b0, ln, "R1 impulse");
    idle(5);
    for (int p = 0; p < NP; p++) ln[p] = p + 1;
    launch(1'b0, ln, "R1 ramp");
    idle(3);

    // R3: constant 16 gives one nonzero bin and seven zero flags
    for (int p = 0; p < NP; p++) ln[p] = 16;
    launch(1'b0, ln, "R3 constant sixteen");
    idle(4);

    // R2: codes above the modulus
    for (int p = 0; p < NP; p++) ln[p] = 17 + 2 * p;
    launch(1'b0, ln, "R2 wide codes");
    idle(4);
    for (int p = 0; p < NP; p++) ln[p] = 31 - p;
    launch(1'b0, ln, "R2 high codes");
    idle(4);

    // R1 and R4: random blocks in both directions
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < NP; p++) ln[p] = $urandom_range(16, 0);
      launch(1'b0, ln, "R1 random forward");
      idle(4);
      for (int p = 0; p < NP; p++) ln[p] = $urandom_range(31, 0);
      launch(1'b1, ln, "R4 random inverse");
      idle(4);
    end

    // R7: back-to-back starts with alternating direction
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < NP; p++) ln[p] = $urandom_range(31, 0);
      launch(1'(r % 2), ln, "R7 back-to-back");
    end
    drain();

    // R5: forward then inverse returns the samples
    for (int m = 0; m < NP; m++) big[m] = 3 * m + 2;
    round_trip(big);
    for (int m = 0; m < NP; m++) big[m] = (m == 5) ? 16 : 0;
    round_trip(big);
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < NP; m++) xs[m] = $urandom_range(16, 0);
      round_trip(xs);
    end

    // R8: inputs toggle with start low, outputs must hold
    idle(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule